// File: doc/BRIEF.md
# Management-Mode Entry/Exit Sequencer

This block steps a processor core into and out of its management mode once an upstream arbiter has granted the request. After the grant it waits for the bus to go quiet and for the external write buffers to report empty. It then writes the saved context as a stack that grows downward from the top of the save area, and presents the address where the handler starts. When the resume command arrives, it reads the same words back in reverse order and reports that the resume is done. The contents of the saved words come from elsewhere. Only the sequence, the addresses and the handshake are handled here.

An active-low output tells system logic to decode the protected save memory. It is low for every access from the first save write to the last restore read. When two processors share the bus, it stays high while this unit does not own the bus. The block also holds the relocatable base of the save area and an I/O-restart enable bit. The enable bit selects the revision identifier the block reports.

Top module: `mgmt_mode_seq`

## Requirements
- R1: After synchronous reset: `mm_active_n` = 1, `mem_valid` = 0, `entry_valid` = 0, `resume_done` = 0, `base_out` = 0x30000, `rev_id` = 0.
- R2: After a grant (`enter_req` high for one cycle while idle), no access is issued while `bus_idle` or `wbuf_empty` is low. The first save write appears in the cycle after the first clock edge at which both are sampled high.
- R3: Entry issues exactly SAVE_WORDS writes (`mem_write` = 1). The first is at `base_out` + 0xFFFF, and each later write is one address lower.
- R4: An access stays presented, with the same address and direction, while `mem_ready` is low. The sequence advances only on a cycle where `mem_valid` and `mem_ready` are both high.
- R5: In the cycle after the last save write is accepted, `entry_valid` is high for exactly one cycle, with `entry_addr` = `base_out` + 0x8000.
- R6: A `resume_req` sampled while the block waits in the handler phase starts SAVE_WORDS reads (`mem_write` = 0). They go from `base_out` + 0xFFFF − (SAVE_WORDS−1) upward to `base_out` + 0xFFFF. In the cycle after the last read is accepted, `resume_done` is high for one cycle and `mm_active_n` is high.
- R7: With `dual_mode` = 0, `mm_active_n` is low in every cycle from the first save write through the last restore read, including the handler phase, and high at all other times.
- R8: With `dual_mode` = 1, `mm_active_n` is high whenever `bus_owner` = 0. If `bus_owner` goes high while the block is still in management mode, `mm_active_n` is low in that same cycle.
- R9: The I/O-restart enable is cleared by reset and written by `rstrt_we`/`rstrt_val`. `rev_id` is 2 when the enable is set and 0 when it is clear, from the cycle after the write.
- R10: `base_load` loads `base_load_val` into the base register only when the block is idle. A load during a sequence leaves `base_out` unchanged.
- R11: `enter_req` during a sequence and `resume_req` outside the handler phase are ignored. They start no extra accesses and do not shorten the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Grant to enter management mode (one-cycle pulse) |
| resume_req | input | 1 | Resume command from the handler |
| bus_idle | input | 1 | High when no bus cycles are outstanding |
| wbuf_empty | input | 1 | High when the external write buffers are empty |
| dual_mode | input | 1 | Two-processor operation selected |
| bus_owner | input | 1 | This unit currently owns the bus |
| base_load | input | 1 | Load the save-area base (honoured only when idle) |
| base_load_val | input | ADDR_W | New base value |
| rstrt_we | input | 1 | Write strobe for the I/O-restart enable |
| rstrt_val | input | 1 | New I/O-restart enable value |
| mem_valid | output | 1 | Memory access presented |
| mem_write | output | 1 | 1 = save write, 0 = restore read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_ready | input | 1 | Memory accepts the presented access |
| mm_active_n | output | 1 | Active-low management-mode indication |
| entry_valid | output | 1 | Handler start address valid (one cycle) |
| entry_addr | output | ADDR_W | Handler start address |
| resume_done | output | 1 | Restore finished (one cycle) |
| base_out | output | ADDR_W | Current save-area base |
| rev_id | output | REV_W | Revision identifier |

## Verification
The bench holds `wbuf_empty` low after `bus_idle` rises, and the reverse. A design that checked only one of the two would start writing early.

Random-looking ready stalls fall on first, middle and last accesses. They catch an address that moves without a handshake, or a save that is one word short or long. Reversing the walk direction, or starting the restore at the wrong end, shows up as an address mismatch on the first read.

Base loads and stray grant or resume pulses are applied in the middle of a sequence, and `mm_active_n` is tested with bus ownership gained late in two-processor mode. A design that relocated mid-sequence, restarted a save, or ignored ownership would disagree with the reference model on the next cycle.

// File: rtl/mgmt_mode_pkg.sv
`timescale 1ns/1ps
package mgmt_mode_pkg;

    // Phases of one entry/exit sequence
    typedef enum logic [2:0] {
        MM_IDLE,
        MM_DRAIN,
        MM_SAVE,
        MM_ENTRY,
        MM_RUN,
        MM_LOAD,
        MM_DONE
    } mm_phase_e;

    // Kind of access the controller is presenting
    typedef struct packed {
        logic valid;
        logic write;
    } mm_access_t;

    localparam int unsigned SAVE_TOP_OFS  = 32'h0000_FFFF;
    localparam int unsigned ENTRY_OFS     = 32'h0000_8000;
    localparam int unsigned BASE_AT_RESET = 32'h0003_0000;
    localparam int unsigned REV_RESTART   = 2;

    function automatic logic phase_in_mode(mm_phase_e p);
        return (p == MM_SAVE) || (p == MM_ENTRY) || (p == MM_RUN) || (p == MM_LOAD);
    endfunction

    function automatic mm_access_t phase_access(mm_phase_e p);
        mm_access_t a;
        a.valid = (p == MM_SAVE) || (p == MM_LOAD);
        a.write = (p == MM_SAVE);
        return a;
    endfunction

endpackage

// File: rtl/mm_seq_ctrl.sv
`timescale 1ns/1ps
module mm_seq_ctrl
    import mgmt_mode_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter_req,
    input  logic             resume_req,
    input  logic             bus_idle,
    input  logic             wbuf_empty,
    input  logic             mem_ready,
    output mm_phase_e        phase,
    output logic [IDX_W-1:0] idx
);

    mm_access_t acc;
    logic       accept;
    logic       at_last;

    always_comb begin
        acc     = phase_access(phase);
        accept  = acc.valid && mem_ready;
        at_last = (idx == IDX_W'(WORDS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= MM_IDLE;
            idx   <= '0;
        end else begin
            unique case (phase)
                MM_IDLE: begin
                    if (enter_req) phase <= MM_DRAIN;
                end
                MM_DRAIN: begin
                    if (bus_idle && wbuf_empty) begin
                        phase <= MM_SAVE;
                        idx   <= '0;
                    end
                end
                MM_SAVE: begin
                    if (accept) begin
                        if (at_last) begin
                            phase <= MM_ENTRY;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                MM_ENTRY: phase <= MM_RUN;
                MM_RUN: begin
                    if (resume_req) begin
                        phase <= MM_LOAD;
                        idx   <= '0;
                    end
                end
                MM_LOAD: begin
                    if (accept) begin
                        if (at_last) begin
                            phase <= MM_DONE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                MM_DONE: phase <= MM_IDLE;
                default: phase <= MM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mm_addr_gen.sv
`timescale 1ns/1ps
module mm_addr_gen
    import mgmt_mode_pkg::*;
#(
    parameter int unsigned AW    = 20,
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  mm_phase_e        phase,
    input  logic [IDX_W-1:0] idx,
    input  logic [AW-1:0]    base,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    entry_addr
);

    localparam logic [AW-1:0] TOP_OFS = AW'(SAVE_TOP_OFS);
    localparam logic [AW-1:0] ENT_OFS = AW'(ENTRY_OFS);

    logic [AW-1:0] top_abs;
    logic [AW-1:0] save_addr;
    logic [AW-1:0] load_addr;

    assign top_abs    = base + TOP_OFS;
    assign save_addr  = top_abs - AW'(idx);
    assign entry_addr = base + ENT_OFS;

    // Restore walks upward from the lowest saved word
    generate
        if (WORDS == 1) begin : g_single
            assign load_addr = top_abs;
        end else begin : g_multi
            localparam logic [AW-1:0] SPAN = AW'(WORDS - 1);
            assign load_addr = top_abs - SPAN + AW'(idx);
        end
    endgenerate

    assign acc_addr = (phase == MM_LOAD) ? load_addr : save_addr;

endmodule

// File: rtl/mm_cfg_regs.sv
`timescale 1ns/1ps
module mm_cfg_regs
    import mgmt_mode_pkg::*;
#(
    parameter int unsigned AW = 20,
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_open,
    input  logic          base_load,
    input  logic [AW-1:0] base_load_val,
    input  logic          rstrt_we,
    input  logic          rstrt_val,
    output logic [AW-1:0] base,
    output logic [RW-1:0] rev_id
);

    logic rstrt_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= AW'(BASE_AT_RESET);
            rstrt_en <= 1'b0;
        end else begin
            if (base_load && cfg_open) base <= base_load_val;
            if (rstrt_we) rstrt_en <= rstrt_val;
        end
    end

    assign rev_id = rstrt_en ? RW'(REV_RESTART) : '0;

endmodule

// File: rtl/mgmt_mode_seq.sv
`timescale 1ns/1ps
module mgmt_mode_seq
    import mgmt_mode_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned SAVE_WORDS = 16,
    parameter int unsigned REV_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              resume_req,
    input  logic              bus_idle,
    input  logic              wbuf_empty,
    input  logic              dual_mode,
    input  logic              bus_owner,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_load_val,
    input  logic              rstrt_we,
    input  logic              rstrt_val,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    output logic              mm_active_n,
    output logic              entry_valid,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              resume_done,
    output logic [ADDR_W-1:0] base_out,
    output logic [REV_W-1:0]  rev_id
);

    localparam int unsigned IDX_W = (SAVE_WORDS > 1) ? $clog2(SAVE_WORDS) : 1;

    mm_phase_e        phase;
    logic [IDX_W-1:0] idx;
    mm_access_t       acc;
    logic             visible;

    mm_seq_ctrl #(.WORDS(SAVE_WORDS)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .enter_req  (enter_req),
        .resume_req (resume_req),
        .bus_idle   (bus_idle),
        .wbuf_empty (wbuf_empty),
        .mem_ready  (mem_ready),
        .phase      (phase),
        .idx        (idx)
    );

    mm_addr_gen #(.AW(ADDR_W), .WORDS(SAVE_WORDS)) addr_i (
        .phase      (phase),
        .idx        (idx),
        .base       (base_out),
        .acc_addr   (mem_addr),
        .entry_addr (entry_addr)
    );

    mm_cfg_regs #(.AW(ADDR_W), .RW(REV_W)) cfg_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_open      (phase == MM_IDLE),
        .base_load     (base_load),
        .base_load_val (base_load_val),
        .rstrt_we      (rstrt_we),
        .rstrt_val     (rstrt_val),
        .base          (base_out),
        .rev_id        (rev_id)
    );

    always_comb begin
        acc         = phase_access(phase);
        mem_valid   = acc.valid;
        mem_write   = acc.write;
        visible     = !dual_mode || bus_owner;
        mm_active_n = !(phase_in_mode(phase) && visible);
        entry_valid = (phase == MM_ENTRY);
        resume_done = (phase == MM_DONE);
    end

endmodule

// File: rtl/mgmt_mode_seq_chk.sv
`timescale 1ns/1ps
module mgmt_mode_seq_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned REV_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dual_mode,
    input logic              bus_owner,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              mm_active_n,
    input logic              entry_valid,
    input logic [ADDR_W-1:0] entry_addr,
    input logic              resume_done,
    input logic [ADDR_W-1:0] base_out,
    input logic [REV_W-1:0]  rev_id
);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> mm_active_n && !mem_valid && base_out == ADDR_W'(32'h30000));

    assert_save_descends_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_write && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    assert_entry_addr_R5: assert property (@(posedge clk) disable iff (rst)
        entry_valid |-> entry_addr == base_out + ADDR_W'(32'h8000));

    assert_restore_ascends_R6: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_write && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_done_inactive_R6: assert property (@(posedge clk) disable iff (rst)
        resume_done |-> mm_active_n && !mem_valid);

    assert_active_on_access_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && (!dual_mode || bus_owner) |-> !mm_active_n);

    assert_not_owner_R8: assert property (@(posedge clk) disable iff (rst)
        dual_mode && !bus_owner |-> mm_active_n);

    assert_rev_values_R9: assert property (@(posedge clk) disable iff (rst)
        rev_id == REV_W'(0) || rev_id == REV_W'(2));

endmodule

bind mgmt_mode_seq mgmt_mode_seq_chk #(.ADDR_W(ADDR_W), .REV_W(REV_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .dual_mode   (dual_mode),
    .bus_owner   (bus_owner),
    .mem_valid   (mem_valid),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_ready   (mem_ready),
    .mm_active_n (mm_active_n),
    .entry_valid (entry_valid),
    .entry_addr  (entry_addr),
    .resume_done (resume_done),
    .base_out    (base_out),
    .rev_id      (rev_id)
);

// File: tb/mgmt_mode_seq_tb_top.sv
`timescale 1ns/1ps
module mgmt_mode_seq_tb_top;

    localparam int AW    = 20;
    localparam int WORDS = 16;
    localparam int RW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enter_req = 0, resume_req = 0, bus_idle = 0, wbuf_empty = 0;
    logic          dual_mode = 0, bus_owner = 0, base_load = 0;
    logic [AW-1:0] base_load_val = '0;
    logic          rstrt_we = 0, rstrt_val = 0, mem_ready = 0;
    logic          mem_valid, mem_write, mm_active_n, entry_valid, resume_done;
    logic [AW-1:0] mem_addr, entry_addr, base_out;
    logic [RW-1:0] rev_id;

    mgmt_mode_seq #(.ADDR_W(AW), .SAVE_WORDS(WORDS), .REV_W(RW)) dut_i (
        .clk(clk), .rst(rst), .enter_req(enter_req), .resume_req(resume_req),
        .bus_idle(bus_idle), .wbuf_empty(wbuf_empty), .dual_mode(dual_mode),
        .bus_owner(bus_owner), .base_load(base_load), .base_load_val(base_load_val),
        .rstrt_we(rstrt_we), .rstrt_val(rstrt_val), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mm_active_n(mm_active_n), .entry_valid(entry_valid), .entry_addr(entry_addr),
        .resume_done(resume_done), .base_out(base_out), .rev_id(rev_id)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit cmp_on   = 0;
    bit ready_all = 0;
    int cyc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // ph: 0 idle, 1 drain, 2 save, 3 handler entry, 4 run, 5 restore, 6 done
    int            ph = 0;
    logic [AW-1:0] m_base = AW'(32'h30000);
    bit            m_rstrt = 0;
    logic [AW-1:0] q[$];

    always @(posedge clk) begin
        int old;
        if (rst) begin
            ph = 0; m_base = AW'(32'h30000); m_rstrt = 0; q.delete();
        end else begin
            old = ph;
            if (rstrt_we) m_rstrt = rstrt_val;
            if (old == 0 && base_load) m_base = base_load_val;
            case (old)
                0: if (enter_req) ph = 1;
                1: if (bus_idle && wbuf_empty) begin
                       for (int i = 0; i < WORDS; i++) q.push_back(AW'(m_base + 32'hFFFF - i));
                       ph = 2;
                   end
                2: if (mem_ready) begin
                       void'(q.pop_front());
                       if (q.size() == 0) ph = 3;
                   end
                3: ph = 4;
                4: if (resume_req) begin
                       for (int i = 0; i < WORDS; i++)
                           q.push_back(AW'(m_base + 32'hFFFF - (WORDS - 1) + i));
                       ph = 5;
                   end
                5: if (mem_ready) begin
                       void'(q.pop_front());
                       if (q.size() == 0) ph = 6;
                   end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst && !finished) begin
            bit m_valid;
            bit m_in;
            m_valid = (ph == 2) || (ph == 5);
            m_in    = (ph >= 2) && (ph <= 5);
            chk("R2 R11 mem_valid", mem_valid, m_valid);
            if (m_valid) begin
                chk("R3 R6 mem_write", mem_write, ph == 2);
                chk("R3 R4 R6 mem_addr", mem_addr, q[0]);
            end
            chk("R7 R8 mm_active_n", mm_active_n, !(m_in && (!dual_mode || bus_owner)));
            chk("R5 entry_valid", entry_valid, ph == 3);
            if (ph == 3) chk("R5 entry_addr", entry_addr, AW'(m_base + 32'h8000));
            chk("R6 resume_done", resume_done, ph == 6);
            chk("R10 base_out", base_out, m_base);
            chk("R9 rev_id", rev_id, m_rstrt ? 2 : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        mem_ready = ready_all ? 1'b1 : ((cyc % 3 != 1) && (cyc % 7 != 3));
    endtask

    task automatic wait_entry();
        for (int k = 0; k < 400 && !entry_valid; k++) tick();
    endtask

    task automatic wait_done();
        for (int k = 0; k < 400 && !resume_done; k++) tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        @(negedge clk);
        chk("R1 mm_active_n", mm_active_n, 1);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 base_out", base_out, 32'h30000);
        chk("R1 rev_id", rev_id, 0);
        chk("R1 entry_valid", entry_valid, 0);
        cmp_on = 1;

        // R9: restart enable selects revision
        tick(); rstrt_we = 1; rstrt_val = 1;
        tick(); rstrt_we = 0;
        @(negedge clk); chk("R9 rev_id set", rev_id, 2);
        tick(); rstrt_we = 1; rstrt_val = 0;
        tick(); rstrt_we = 0;
        @(negedge clk); chk("R9 rev_id clear", rev_id, 0);

        // Sequence 1: drain gating, stalls, stray inputs
        tick(); enter_req = 1;
        tick(); enter_req = 0;
        repeat (4) tick();
        @(negedge clk); chk("R2 no access while busy", mem_valid, 0);
        tick(); bus_idle = 1;
        repeat (3) tick();
        @(negedge clk); chk("R2 no access with buffers full", mem_valid, 0);
        tick(); wbuf_empty = 1;
        for (int k = 0; k < 20 && !mem_valid; k++) tick();
        chk("R3 first save address", mem_addr, 32'h3FFFF);
        repeat (3) tick();
        enter_req = 1; resume_req = 1; base_load = 1; base_load_val = AW'(32'h70000);
        tick(); enter_req = 0; resume_req = 0; base_load = 0;
        @(negedge clk); chk("R10 base kept mid-sequence", base_out, 32'h30000);
        chk("R11 save still running", mem_write & mem_valid, 1);
        wait_entry();
        chk("R5 entry address", entry_addr, 32'h38000);
        repeat (4) tick();
        @(negedge clk); chk("R7 active in handler", mm_active_n, 0);
        chk("R11 no access in handler", mem_valid, 0);
        tick(); resume_req = 1;
        tick(); resume_req = 0;
        @(negedge clk); chk("R6 first restore address", mem_addr, 32'h3FFF0);
        wait_done();
        chk("R6 resume_done", resume_done, 1);
        chk("R6 inactive at done", mm_active_n, 1);

        // Sequence 2: relocated base, two-processor ownership
        tick(); base_load = 1; base_load_val = AW'(32'h50000);
        tick(); base_load = 0;
        @(negedge clk); chk("R10 base loaded when idle", base_out, 32'h50000);
        tick(); dual_mode = 1; bus_owner = 0; rstrt_we = 1; rstrt_val = 1; enter_req = 1;
        tick(); rstrt_we = 0; enter_req = 0;
        wait_entry();
        chk("R5 relocated entry", entry_addr, 32'h58000);
        chk("R8 inactive while not owner", mm_active_n, 1);
        tick(); bus_owner = 1;
        @(negedge clk); chk("R8 active once owner", mm_active_n, 0);
        tick(); resume_req = 1;
        tick(); resume_req = 0;
        wait_done();
        chk("R6 done in dual mode", resume_done, 1);

        // Sequence 3: no stalls
        tick(); dual_mode = 0; ready_all = 1; enter_req = 1;
        tick(); enter_req = 0;
        for (int k = 0; k < 20 && !mem_valid; k++) tick();
        chk("R3 first save relocated", mem_addr, 32'h5FFFF);
        wait_entry();
        tick(); resume_req = 1;
        tick(); resume_req = 0;
        @(negedge clk); chk("R6 first restore relocated", mem_addr, 32'h5FFF0);
        wait_done();
        chk("R6 final done", resume_done, 1);
        repeat (3) tick();

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-related run: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule